// File: doc/BRIEF.md
# ADC Channel Sequencer with Result Tagging

This block sits between an analog converter's control logic and the software-visible result registers. It keeps the mask of enabled input channels and decides which channel the converter samples next. In ascending mode it steps through the enabled channels from low to high and wraps around. In programmed mode it walks a table of sixteen 4-bit channel slots held in two 32-bit sequence words.

Each finished conversion arrives as a single-cycle event that carries a 12-bit sample. The block files the sample into that channel's result register and raises the channel's data-ready flag. If the previous sample for that channel has not been read, it also raises the channel's overrun flag. It keeps a copy of the most recent sample. When tagging is on, that copy carries the number of the channel that produced it.

Software selects a channel on the read port. A read strobe consumes the selected result, which clears its flags. Converter timing, clocking and analog settings are outside this block.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After a synchronous reset the following are all zero: the enable mask, every result register, the data-ready flags, the overrun flags and the last-sample word. `cur_valid` is low.
- R2: `wr_sel` selects the write target: 0 = enable-set, 1 = enable-clear, 2 = low sequence word, 3 = high sequence word. On an enable-set write, each 1 in `wr_data[15:0]` enables that channel. On an enable-clear write, each 1 disables that channel. Zero bits change nothing. `chan_status` shows the mask from the cycle after the write.
- R3: With `seq_mode` low, `cur_chan` is the lowest enabled channel at or above an internal scan pointer, searching with wrap-around from 15 to 0. Each accepted conversion moves the pointer to one above the channel just converted.
- R4: Slot n (n = 0..7) is stored at bits 4n+3:4n of the low sequence word. Slot n (n = 8..15) is stored at bits 4(n-8)+3:4(n-8) of the high sequence word. A write to a sequence word replaces all eight of its slots.
- R5: With `seq_mode` high, `cur_chan` is the channel held in slot i. Here i is a slot index that advances by one on each accepted conversion. Let N be the number of enabled channels. Only slots 0..N-1 are used: an index at or past N selects slot 0, and the index after slot N-1 is slot 0.
- R6: When no channel is enabled, `cur_valid` is low and a conversion event stores nothing.
- R7: An accepted conversion writes its sample into the result register of `cur_chan`. `rd_data` shows the result register named by `rd_chan`. For `rd_chan` values 16 to 31, `rd_data` is zero.
- R8: Each accepted conversion loads `last_data`. Bits 11:0 hold the sample. Bits 15:12 hold the channel number if `tag_en` was high during that conversion cycle, and zero otherwise.
- R9: An accepted conversion sets the channel's data-ready flag. It also sets the channel's overrun flag if the data-ready flag was already set and the same cycle does not read that channel.
- R10: A read strobe with `rd_chan` below 16 clears that channel's data-ready and overrun flags. If a conversion for the same channel lands in that cycle, the data-ready flag ends set and the overrun flag ends clear. A strobe with `rd_chan` of 16 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target (0 set, 1 clear, 2 low slots, 3 high slots) |
| wr_data | input | 32 | Write data |
| seq_mode | input | 1 | 1 = programmed slot order, 0 = ascending order |
| tag_en | input | 1 | Put the channel number into the last-sample word |
| conv_done | input | 1 | One-cycle conversion-finished event |
| conv_result | input | 12 | Sample carried by the event |
| rd_strobe | input | 1 | Consume the result selected by rd_chan |
| rd_chan | input | 5 | Channel selected for reading |
| cur_chan | output | 4 | Channel to convert next |
| cur_valid | output | 1 | At least one channel enabled |
| rd_data | output | 12 | Result of the selected channel |
| last_data | output | 16 | Tag and value of the most recent sample |
| chan_status | output | 16 | Enable mask |
| drdy_flags | output | 16 | Per-channel data-ready flags |
| ovr_flags | output | 16 | Per-channel overrun flags |

## Verification
The bench targets wrap-around in both orderings:
- an ascending scan that fails to wrap from the highest enabled channel back to the lowest would stall or show a disabled channel;
- a programmed sequence that fails to wrap after the last used slot would wander into slots that are not in use.

It shrinks the enable mask while the slot index points past the new count; a design that does not fall back to slot 0 then selects a stale slot.

It lands a conversion and a read on the same channel in one cycle; a design with the wrong precedence either raises a false overrun or loses the data-ready flag.

It also sends conversions with nothing enabled, and reads and strobes at channel numbers 16 to 31; a design that misdecodes either one corrupts a stored result or its flags.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CHAN_W   = 4;
    localparam int NUM_CHAN = 1 << CHAN_W;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 32;

    typedef logic [CHAN_W-1:0]   chan_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        WR_EN_SET = 2'd0,
        WR_EN_CLR = 2'd1,
        WR_SEQ_LO = 2'd2,
        WR_SEQ_HI = 2'd3
    } wr_target_e;

    typedef struct packed {
        chan_t   tag;
        sample_t value;
    } last_word_t;

endpackage

// File: rtl/adcseq_enable_reg.sv
module adcseq_enable_reg
    import adcseq_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int WW  = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  wr_target_e     wr_sel,
    input  logic [WW-1:0]  wr_data,
    output logic [NCH-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                WR_EN_SET: mask <= mask | wr_data[NCH-1:0];
                WR_EN_CLR: mask <= mask & ~wr_data[NCH-1:0];
                default:   mask <= mask;
            endcase
        end
    end

    // R2: set bits appear, clear bits disappear
    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == WR_EN_SET) |=>
            ((mask & $past(wr_data[NCH-1:0])) == $past(wr_data[NCH-1:0])));

    a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == WR_EN_CLR) |=>
            ((mask & $past(wr_data[NCH-1:0])) == '0));

    a_r2_seq_write_keeps_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == WR_SEQ_LO || wr_sel == WR_SEQ_HI)) |=> $stable(mask));

endmodule

// File: rtl/adcseq_slot_table.sv
module adcseq_slot_table
    import adcseq_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W,
    parameter int WW  = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  wr_target_e    wr_sel,
    input  logic [WW-1:0] wr_data,
    input  logic [CW-1:0] slot_idx,
    output logic [CW-1:0] slot_chan
);

    localparam int SLOTS_PER_WORD = WW / CW;

    logic [CW-1:0] slots [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NCH; s++) slots[s] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NCH; s++) begin
                if ((s < SLOTS_PER_WORD && wr_sel == WR_SEQ_LO) ||
                    (s >= SLOTS_PER_WORD && wr_sel == WR_SEQ_HI))
                    slots[s] <= wr_data[(s % SLOTS_PER_WORD)*CW +: CW];
            end
        end
    end

    assign slot_chan = slots[slot_idx];

    // R4: first slot of each word comes from the word's lowest nibble
    a_r4_low_word_slot0: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == WR_SEQ_LO) |=> (slots[0] == $past(wr_data[CW-1:0])));

    a_r4_high_word_slot8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == WR_SEQ_HI) |=> (slots[SLOTS_PER_WORD] == $past(wr_data[CW-1:0])));

endmodule

// File: rtl/adcseq_picker.sv
module adcseq_picker
    import adcseq_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] mask,
    input  logic           seq_mode,
    input  logic           advance,
    input  logic [CW-1:0]  slot_chan,
    output logic [CW-1:0]  slot_idx,
    output logic [CW-1:0]  cur_chan,
    output logic           cur_valid
);

    function automatic logic [CW:0] count_ones(input logic [NCH-1:0] m);
        logic [CW:0] c;
        c = '0;
        for (int i = 0; i < NCH; i++) c = c + (CW+1)'(m[i]);
        return c;
    endfunction

    function automatic logic [CW-1:0] first_from(input logic [NCH-1:0] m,
                                                 input logic [CW-1:0] p);
        logic [CW-1:0] r;
        logic          hit;
        int            k;
        r   = '0;
        hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            k = (int'(p) + i) % NCH;
            if (!hit && m[k]) begin
                hit = 1'b1;
                r   = CW'(k);
            end
        end
        return r;
    endfunction

    logic [CW-1:0] asc_ptr;
    logic [CW-1:0] seq_idx;
    logic [CW:0]   enabled_cnt;
    logic [CW-1:0] asc_chan;

    assign enabled_cnt = count_ones(mask);
    assign slot_idx    = ({1'b0, seq_idx} < enabled_cnt) ? seq_idx : '0;
    assign asc_chan    = first_from(mask, asc_ptr);
    assign cur_valid   = |mask;
    assign cur_chan    = seq_mode ? slot_chan : asc_chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            asc_ptr <= '0;
            seq_idx <= '0;
        end else if (advance) begin
            if (seq_mode) seq_idx <= slot_idx + 1'b1;
            else          asc_ptr <= asc_chan + 1'b1;
        end
    end

    // R3: ascending mode never points at a disabled channel
    a_r3_asc_enabled: assert property (@(posedge clk) disable iff (rst)
        (cur_valid && !seq_mode) |-> mask[cur_chan]);

    // R5: slot index stays inside the enabled count
    a_r5_index_in_range: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> ({1'b0, slot_idx} < enabled_cnt));

endmodule

// File: rtl/adcseq_result_bank.sv
module adcseq_result_bank
    import adcseq_pkg::*;
#(
    parameter int NCH = NUM_CHAN,
    parameter int CW  = CHAN_W,
    parameter int DW  = SAMPLE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic [CW-1:0]  cur_chan,
    input  logic [DW-1:0]  result,
    input  logic           tag_en,
    input  logic           rd_strobe,
    input  logic [CW:0]    rd_chan,
    output logic [DW-1:0]  rd_data,
    output last_word_t     last_word,
    output logic [NCH-1:0] drdy,
    output logic [NCH-1:0] ovr
);

    logic [DW-1:0]  data_q [NCH];
    logic [NCH-1:0] conv_hit;
    logic [NCH-1:0] read_hit;

    always_comb begin
        for (int g = 0; g < NCH; g++) begin
            conv_hit[g] = advance   && (cur_chan == CW'(g));
            read_hit[g] = rd_strobe && (rd_chan == (CW+1)'(g));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NCH; g++) data_q[g] <= '0;
            drdy      <= '0;
            ovr       <= '0;
            last_word <= '0;
        end else begin
            for (int g = 0; g < NCH; g++) begin
                if (conv_hit[g]) begin
                    data_q[g] <= result;
                    drdy[g]   <= 1'b1;
                    ovr[g]    <= (drdy[g] & ~read_hit[g]) | (ovr[g] & ~read_hit[g]);
                end else if (read_hit[g]) begin
                    drdy[g] <= 1'b0;
                    ovr[g]  <= 1'b0;
                end
            end
            if (advance) begin
                last_word.tag   <= tag_en ? cur_chan : '0;
                last_word.value <= result;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_chan < (CW+1)'(NCH)) rd_data = data_q[rd_chan[CW-1:0]];
    end

    // R9: an overrun is only ever reported on a channel holding unread data
    a_r9_ovr_needs_drdy: assert property (@(posedge clk) disable iff (rst)
        (ovr & ~drdy) == '0);

    // R8: last word follows each accepted sample
    a_r8_last_value: assert property (@(posedge clk) disable iff (rst)
        advance |=> (last_word.value == $past(result)));

    a_r8_untagged_zero: assert property (@(posedge clk) disable iff (rst)
        (advance && !tag_en) |=> (last_word.tag == '0));

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chk
            // R9: a second unread sample flags overrun
            a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
                (conv_hit[gi] && drdy[gi] && !read_hit[gi]) |=> ovr[gi]);
            // R10: a read without a colliding sample clears both flags
            a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
                (read_hit[gi] && !conv_hit[gi]) |=> (!drdy[gi] && !ovr[gi]));
        end
    endgenerate

endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
    import adcseq_pkg::*;
#(
    parameter int CW = CHAN_W,
    parameter int DW = SAMPLE_W,
    parameter int WW = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WW-1:0]     wr_data,
    input  logic              seq_mode,
    input  logic              tag_en,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_result,
    input  logic              rd_strobe,
    input  logic [CW:0]       rd_chan,
    output logic [CW-1:0]     cur_chan,
    output logic              cur_valid,
    output logic [DW-1:0]     rd_data,
    output logic [CW+DW-1:0]  last_data,
    output logic [(1<<CW)-1:0] chan_status,
    output logic [(1<<CW)-1:0] drdy_flags,
    output logic [(1<<CW)-1:0] ovr_flags
);

    localparam int NCH = 1 << CW;

    wr_target_e    wr_target;
    logic          advance;
    logic [CW-1:0] slot_idx;
    logic [CW-1:0] slot_chan;
    last_word_t    last_word;

    assign wr_target = wr_target_e'(wr_sel);
    assign advance   = conv_done & cur_valid;
    assign last_data = last_word;

    adcseq_enable_reg #(.NCH(NCH), .WW(WW)) u_enable (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_target),
        .wr_data(wr_data), .mask(chan_status)
    );

    adcseq_slot_table #(.NCH(NCH), .CW(CW), .WW(WW)) u_slots (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_target),
        .wr_data(wr_data), .slot_idx(slot_idx), .slot_chan(slot_chan)
    );

    adcseq_picker #(.NCH(NCH), .CW(CW)) u_picker (
        .clk(clk), .rst(rst), .mask(chan_status), .seq_mode(seq_mode),
        .advance(advance), .slot_chan(slot_chan), .slot_idx(slot_idx),
        .cur_chan(cur_chan), .cur_valid(cur_valid)
    );

    adcseq_result_bank #(.NCH(NCH), .CW(CW), .DW(DW)) u_results (
        .clk(clk), .rst(rst), .advance(advance), .cur_chan(cur_chan),
        .result(conv_result), .tag_en(tag_en), .rd_strobe(rd_strobe),
        .rd_chan(rd_chan), .rd_data(rd_data), .last_word(last_word),
        .drdy(drdy_flags), .ovr(ovr_flags)
    );

    // R6: an event with nothing enabled leaves the last sample alone
    a_r6_idle_ignored: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !cur_valid) |=> $stable(last_data));

    // R3: with two or more channels enabled, ascending mode moves on
    a_r3_asc_moves: assert property (@(posedge clk) disable iff (rst)
        (advance && !seq_mode && $countones(chan_status) > 1 && !wr_en) |=>
            (seq_mode || cur_chan != $past(cur_chan)));

endmodule

// File: tb/tb_adc_chan_sequencer.sv
`timescale 1ns/1ps
module tb_adc_chan_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        seq_mode = 1'b0;
    logic        tag_en = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        rd_strobe = 1'b0;
    logic [4:0]  rd_chan = '0;
    logic [3:0]  cur_chan;
    logic        cur_valid;
    logic [11:0] rd_data;
    logic [15:0] last_data;
    logic [15:0] chan_status;
    logic [15:0] drdy_flags;
    logic [15:0] ovr_flags;

    adc_chan_sequencer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seq_mode(seq_mode), .tag_en(tag_en), .conv_done(conv_done),
        .conv_result(conv_result), .rd_strobe(rd_strobe), .rd_chan(rd_chan),
        .cur_chan(cur_chan), .cur_valid(cur_valid), .rd_data(rd_data),
        .last_data(last_data), .chan_status(chan_status),
        .drdy_flags(drdy_flags), .ovr_flags(ovr_flags)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    bit [15:0] m_en, m_drdy, m_ovr;
    int m_slot [16];
    int m_data [16];
    int m_last, m_aptr, m_sidx;
    int n_en, e_idx, e_ch, rc;
    bit rdv;

    function automatic int popc(bit [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += m[i];
        return c;
    endfunction

    function automatic int exp_idx();
        return (m_sidx < popc(m_en)) ? m_sidx : 0;
    endfunction

    function automatic int exp_chan();
        if (seq_mode) return m_slot[exp_idx()];
        for (int i = 0; i < 16; i++)
            if (m_en[(m_aptr + i) % 16]) return (m_aptr + i) % 16;
        return 0;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_en = '0; m_drdy = '0; m_ovr = '0; m_last = 0; m_aptr = 0; m_sidx = 0;
            for (int i = 0; i < 16; i++) begin m_slot[i] = 0; m_data[i] = 0; end
        end else begin
            n_en = popc(m_en);
            e_idx = exp_idx();
            e_ch = exp_chan();
            rc = int'(rd_chan);
            rdv = rd_strobe && rc < 16;
            if (rdv) begin m_drdy[rc] = 1'b0; m_ovr[rc] = 1'b0; end
            if (conv_done && n_en > 0) begin
                if (m_drdy[e_ch]) m_ovr[e_ch] = 1'b1;
                m_drdy[e_ch] = 1'b1;
                m_data[e_ch] = int'(conv_result);
                m_last = (tag_en ? (e_ch << 12) : 0) | int'(conv_result);
                if (seq_mode) m_sidx = (e_idx + 1) % 16;
                else          m_aptr = (e_ch + 1) % 16;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_en = m_en | wr_data[15:0];
                    2'd1: m_en = m_en & ~wr_data[15:0];
                    2'd2: for (int s = 0; s < 8; s++) m_slot[s]   = int'((wr_data >> (4*s)) & 32'hF);
                    default: for (int s = 0; s < 8; s++) m_slot[s+8] = int'((wr_data >> (4*s)) & 32'hF);
                endcase
            end
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (started && !rst) begin
            chk("R2 status", chan_status, m_en);
            chk("R6 cur_valid", cur_valid, m_en != 0);
            if (m_en != 0)
                chk(seq_mode ? "R4 R5 seq chan" : "R3 asc chan", cur_chan, exp_chan());
            chk("R7 rd_data", rd_data, (int'(rd_chan) < 16) ? m_data[rd_chan[3:0]] : 0);
            chk("R8 last_data", last_data, m_last);
            chk("R9 drdy", drdy_flags, m_drdy);
            chk("R10 ovr", ovr_flags, m_ovr);
        end
    end

    task automatic cyc(bit we, bit [1:0] ws, bit [31:0] wd, bit cv, bit [11:0] res,
                       bit rs, bit [4:0] rch);
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        conv_done = cv; conv_result = res; rd_strobe = rs; rd_chan = rch;
    endtask

    task automatic conv(bit [11:0] v); cyc(0, 0, 0, 1, v, 0, 5'd0); endtask
    task automatic wr(bit [1:0] s, bit [31:0] d); cyc(1, s, d, 0, 0, 0, 5'd0); endtask
    task automatic rd(bit [4:0] c); cyc(0, 0, 0, 0, 0, 1, c); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 status", chan_status, 0);
        chk("R1 valid", cur_valid, 0);
        chk("R1 last", last_data, 0);
        chk("R1 drdy", drdy_flags, 0);
        chk("R1 ovr", ovr_flags, 0);
        chk("R1 data", rd_data, 0);
        started = 1;

        // ascending order over channels 2, 5, 9 with wrap and overrun
        wr(0, 32'h0000_0224);
        conv(12'h111); conv(12'h222); conv(12'h333); conv(12'h444);
        rd(5'd2); rd(5'd20); cyc(0, 0, 0, 0, 0, 1, 5'd31); rd(5'd5);
        // zero set has no effect; clear one channel
        wr(0, 32'h0); wr(1, 32'h0000_0020);
        // conversion and read on the same channel together
        cyc(0, 0, 0, 1, 12'h555, 1, 5'd9);
        cyc(0, 0, 0, 1, 12'h666, 1, 5'd2);
        cyc(0, 0, 0, 1, 12'h777, 1, 5'd9);
        // tagging on and off
        tag_en = 1'b1;
        conv(12'hABC); conv(12'hDEF); conv(12'h123);
        tag_en = 1'b0;
        conv(12'h321);
        // programmed order
        wr(2, 32'h1F3A_0C97);
        wr(3, 32'h2468_ACE5);
        wr(0, 32'h0000_00F0);
        seq_mode = 1'b1;
        for (int i = 0; i < 14; i++) conv(12'(i * 37 + 5));
        conv(12'h010); conv(12'h020); conv(12'h030);
        wr(1, 32'h0000_00F4);
        for (int i = 0; i < 5; i++) conv(12'(i + 100));
        wr(0, 32'h0000_FFFF);
        tag_en = 1'b1;
        for (int i = 0; i < 20; i++) conv(12'(i * 91));
        seq_mode = 1'b0;
        for (int i = 0; i < 18; i++) conv(12'(i * 13 + 1));
        for (int i = 0; i < 32; i++) rd(5'(i));
        // nothing enabled: events ignored
        wr(1, 32'h0000_FFFF);
        conv(12'hFFF); conv(12'hEEE); conv(12'hDDD);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, 0, 5'(i));
        // mixed stimulus
        for (int i = 0; i < 500; i++) begin
            seq_mode = ($urandom % 4) == 0;
            tag_en = $urandom % 2;
            cyc(($urandom % 5) == 0, 2'($urandom), $urandom,
                ($urandom % 2) == 0, 12'($urandom), ($urandom % 3) == 0, 5'($urandom));
        end
        cyc(0, 0, 0, 0, 0, 0, 5'd0);
        @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule